// File: doc/BRIEF.md
# MAC Destination Address Hash Filter

This block decides whether a received frame's 48-bit destination address is in an address table. It folds the address into an 11-bit slot number and then searches a 2048-slot on-chip table. The search starts at that slot and steps upward one slot per clock, wrapping from the top slot back to slot 0. It stops at the first matching entry, at the first empty slot, or when the hop budget runs out.

Each search returns exactly one result strobe. The strobe carries:
- a hit flag;
- two attribute flags copied from the matching entry: reject, derived from the skip bit, and a receive attribute;
- the slot the search ended on;
- the number of slots examined.

Software fills the table through a plain write port. Each write loads one slot with a low word and a high word, in the packed entry format given below.

A lookup is offered with `lk_valid` and is accepted on a clock edge where `lk_ready` is high. While a search is in flight, `lk_ready` stays low and new requests are ignored. The table is a synchronous-read RAM, so each probe costs one clock.

Top module: `mac_hash_filter`

## Requirements
- R1: The start slot is formed as follows. Reverse the bit order inside each of the six octets of the address. Take H as the reversed top two octets and L as the reversed lower four octets. Form p = L[7:2], q = {L[14:8], L[1:0]}, r = L[23:15] and s = {H[0], L[31:24]}. The start slot is the low 11 bits of (p·512) | (q ^ r ^ s). A first-probe hit reports this slot on `res_index`.
- R2: Entry low-word bit 0 is valid, bit 1 is skip and bit 2 is the receive attribute. The address key is stored in low-word bits 31:3 and high-word bits 18:0. Write M for address bits 47:32 and N for address bits 31:0. The low word, from bit 31 down to bit 3, holds N[20], N[19:16], N[31:28], N[27:24], M[7:4], M[3:0], M[15:12] and M[11:8]. The high word, from bit 18 down to bit 0, holds N[7:4], N[3:0], N[15:12], N[11:8] and N[23:21], with bits 31:19 zero. A slot matches when it is valid, its low word equals the key in bits 31:3, and all 32 bits of its high word equal the key. Bits 2:1 play no part in the compare.
- R3: A slot whose valid bit is clear ends the search as a miss.
- R4: After slot 2047 the search continues at slot 0.
- R5: At most HOPS slots are examined, with HOPS defaulting to 12. If HOPS valid non-matching slots are examined, the result is a miss with `res_probes` equal to HOPS.
- R6: Every accepted request yields exactly one `res_valid` pulse, one cycle wide. The pulse comes `res_probes` clock edges after the accepting edge, which means one slot is examined per cycle. On a miss, `res_index` is the last slot examined.
- R7: `res_reject` is the skip bit of the matching entry and `res_rx_attr` is its receive-attribute bit. Both are 0 on a miss.
- R8: `lk_ready` goes low on the edge after a request is accepted and returns high with `res_valid`. A request raised while `lk_ready` is low produces no result.
- R9: While reset is applied and after it is released, `lk_ready` is 1 and `res_valid` is 0.
- R10: A slot written through the write port is seen by any lookup issued after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table slot |
| wr_index | input | 11 | Slot to write |
| wr_lo | input | 32 | Low word of the entry |
| wr_hi | input | 32 | High word of the entry |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination address to look up |
| lk_ready | output | 1 | Block idle, request accepted on this edge |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Matching entry found |
| res_reject | output | 1 | Hit on an entry marked skip |
| res_rx_attr | output | 1 | Receive attribute of the matching entry |
| res_index | output | 11 | Slot where the search ended |
| res_probes | output | $clog2(HOPS+1) | Slots examined |

## Verification
Two cases are hard to reach from the ports: a search that wraps past the top slot, and a search that uses up its whole hop budget. Both need an address that hashes to a particular slot, with a run of valid decoy entries behind it. The stimulus handles this in two steps. First, the bench's own hash function searches random addresses until one lands on slot 2046, or on a chosen start slot. Then decoys are written ahead of the target through the write port, so the matching entry sits exactly past the wrap or exactly at, or one slot beyond, the hop limit. Random clusters of decoys in front of ordinary inserted addresses cover the multi-probe paths. A one-bit address flip and a one-bit change to a stored entry cover the compare.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int IDX_W   = 11;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = 2;
    localparam int KLO_W   = 29;
    localparam int KHI_W   = 19;
    localparam int BIT_VLD = 0;
    localparam int BIT_SKP = 1;
    localparam int BIT_RXA = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PROBE = 1'b1
    } probe_state_e;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [47:0]      mac,
    output logic [IDX_W-1:0] start_idx,
    output logic [KLO_W-1:0] key_lo,
    output logic [KHI_W-1:0] key_hi
);
    localparam int NBYTES = 6;

    logic [47:0] flipped;
    logic [15:0] hword;
    logic [31:0] lword;
    logic [5:0]  fa;
    logic [8:0]  fb, fc, fd;
    logic [15:0] m_hi;
    logic [31:0] m_lo;

    // bit order reversed inside every octet
    for (genvar b = 0; b < NBYTES; b++) begin : g_oct
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign flipped[b*8 + i] = mac[b*8 + 7 - i];
        end
    end

    assign hword = flipped[47:32];
    assign lword = flipped[31:0];

    assign fa = lword[7:2];
    assign fb = {lword[14:8], lword[1:0]};
    assign fc = lword[23:15];
    assign fd = {hword[0], lword[31:24]};

    assign start_idx = {fa[1:0], fb ^ fc ^ fd};

    // packed key as stored in table entries
    assign m_hi = mac[47:32];
    assign m_lo = mac[31:0];

    assign key_lo = {m_lo[20], m_lo[19:16], m_lo[31:28], m_lo[27:24],
                     m_hi[7:4], m_hi[3:0], m_hi[15:12], m_hi[11:8]};
    assign key_hi = {m_lo[7:4], m_lo[3:0], m_lo[15:12], m_lo[11:8],
                     m_lo[23:21]};
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
    parameter int AW = 11,
    parameter int DW = 32,
    parameter int NW = 2
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [NW-1:0][DW-1:0]  wr_data,
    input  logic                   rd_en,
    input  logic [AW-1:0]          rd_addr,
    output logic [NW-1:0][DW-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [DW-1:0] mem [DEPTH];
        logic [DW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data[w];
            end
            if (rd_en) begin
                rd_q <= mem[rd_addr];
            end
        end

        assign rd_data[w] = rd_q;
    end
endmodule

// File: rtl/mhf_probe.sv
module mhf_probe
    import mhf_pkg::*;
#(
    parameter int HOPS = 12,
    parameter int CW   = $clog2(HOPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [KLO_W-1:0]  req_klo,
    input  logic [KHI_W-1:0]  req_khi,
    output logic              req_ready,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0] ent_lo,
    input  logic [WORD_W-1:0] ent_hi,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_reject,
    output logic              res_rx_attr,
    output logic [IDX_W-1:0]  res_index,
    output logic [CW-1:0]     res_probes
);
    localparam logic [CW-1:0] LAST_HOP = CW'(HOPS - 1);

    typedef struct packed {
        probe_state_e     state;
        logic [KLO_W-1:0] klo;
        logic [KHI_W-1:0] khi;
        logic [IDX_W-1:0] slot;
        logic [CW-1:0]    hops;
        logic             valid;
        logic             hit;
        logic             reject;
        logic             rxa;
        logic [IDX_W-1:0] index;
        logic [CW-1:0]    probes;
    } probe_s;

    probe_s q, d;
    logic   slot_vld;
    logic   slot_match;
    logic   stop;

    always_comb begin
        slot_vld   = ent_lo[BIT_VLD];
        slot_match = slot_vld
                   && (ent_lo[WORD_W-1:3] == q.klo)
                   && (ent_hi == WORD_W'(q.khi));
        stop       = slot_match || !slot_vld || (q.hops == LAST_HOP);

        d       = q;
        d.valid = 1'b0;
        rd_en   = 1'b0;
        rd_addr = q.slot + 1'b1;

        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state = ST_PROBE;
                    d.klo   = req_klo;
                    d.khi   = req_khi;
                    d.slot  = req_idx;
                    d.hops  = '0;
                    rd_en   = 1'b1;
                    rd_addr = req_idx;
                end
            end
            ST_PROBE: begin
                if (stop) begin
                    d.state  = ST_IDLE;
                    d.valid  = 1'b1;
                    d.hit    = slot_match;
                    d.reject = slot_match && ent_lo[BIT_SKP];
                    d.rxa    = slot_match && ent_lo[BIT_RXA];
                    d.index  = q.slot;
                    d.probes = CW'(q.hops + 1'b1);
                end else begin
                    d.slot = q.slot + 1'b1;
                    d.hops = CW'(q.hops + 1'b1);
                    rd_en  = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.state == ST_IDLE);
    assign res_valid   = q.valid;
    assign res_hit     = q.hit;
    assign res_reject  = q.reject;
    assign res_rx_attr = q.rxa;
    assign res_index   = q.index;
    assign res_probes  = q.probes;
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int HOPS = 12,
    localparam int CW  = $clog2(HOPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [WORD_W-1:0] wr_lo,
    input  logic [WORD_W-1:0] wr_hi,
    input  logic              lk_valid,
    input  logic [47:0]       lk_mac,
    output logic              lk_ready,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_reject,
    output logic              res_rx_attr,
    output logic [IDX_W-1:0]  res_index,
    output logic [CW-1:0]     res_probes
);
    logic [IDX_W-1:0]               h_idx;
    logic [KLO_W-1:0]               h_klo;
    logic [KHI_W-1:0]               h_khi;
    logic                           t_rd_en;
    logic [IDX_W-1:0]               t_rd_addr;
    logic [NWORDS-1:0][WORD_W-1:0]  t_wr_data;
    logic [NWORDS-1:0][WORD_W-1:0]  t_rd_data;

    assign t_wr_data = {wr_hi, wr_lo};

    mhf_hash u_hash (
        .mac       (lk_mac),
        .start_idx (h_idx),
        .key_lo    (h_klo),
        .key_hi    (h_khi)
    );

    mhf_table #(
        .AW (IDX_W),
        .DW (WORD_W),
        .NW (NWORDS)
    ) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_index),
        .wr_data (t_wr_data),
        .rd_en   (t_rd_en),
        .rd_addr (t_rd_addr),
        .rd_data (t_rd_data)
    );

    mhf_probe #(
        .HOPS (HOPS),
        .CW   (CW)
    ) u_probe (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (lk_valid),
        .req_idx     (h_idx),
        .req_klo     (h_klo),
        .req_khi     (h_khi),
        .req_ready   (lk_ready),
        .rd_en       (t_rd_en),
        .rd_addr     (t_rd_addr),
        .ent_lo      (t_rd_data[0]),
        .ent_hi      (t_rd_data[1]),
        .res_valid   (res_valid),
        .res_hit     (res_hit),
        .res_reject  (res_reject),
        .res_rx_attr (res_rx_attr),
        .res_index   (res_index),
        .res_probes  (res_probes)
    );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int HOPS = 12,
    parameter int CW   = $clog2(HOPS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic          lk_ready,
    input logic          res_valid,
    input logic          res_hit,
    input logic          res_reject,
    input logic          res_rx_attr,
    input logic [CW-1:0] res_probes
);
    logic        pending;
    logic [CW:0] since;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            since   <= '0;
        end else if (lk_valid && lk_ready) begin
            pending <= 1'b1;
            since   <= '0;
        end else begin
            if (res_valid) begin
                pending <= 1'b0;
            end
            if (pending && !since[CW]) begin
                since <= since + 1'b1;
            end
        end
    end

    a_r6_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (pending && (since == (CW+1)'(res_probes))));

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !lk_ready);

    a_r8_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> lk_ready);

    a_r7_reject_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_reject) |-> res_hit);

    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (!res_reject && !res_rx_attr));

    a_r5_probe_bound: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_probes >= 1) && (res_probes <= CW'(HOPS))));
endmodule

bind mac_hash_filter mhf_checker #(
    .HOPS (HOPS)
) u_mhf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_reject  (res_reject),
    .res_rx_attr (res_rx_attr),
    .res_probes  (res_probes)
);

// File: tb/mac_hash_filter_test.sv
module mac_hash_filter_test;
    localparam int HOPS = 12;
    localparam int CW   = $clog2(HOPS + 1);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [10:0] wr_index;
    logic [31:0] wr_lo, wr_hi;
    logic        lk_valid;
    logic [47:0] lk_mac;
    logic        lk_ready, res_valid, res_hit, res_reject, res_rx_attr;
    logic [10:0] res_index;
    logic [CW-1:0] res_probes;

    always #4 clk = ~clk;

    mac_hash_filter #(.HOPS(HOPS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_index(wr_index),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .lk_valid(lk_valid), .lk_mac(lk_mac),
        .lk_ready(lk_ready), .res_valid(res_valid), .res_hit(res_hit),
        .res_reject(res_reject), .res_rx_attr(res_rx_attr),
        .res_index(res_index), .res_probes(res_probes)
    );

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] m_lo [2048];
    logic [31:0] m_hi [2048];

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [10:0] f_hash(input logic [47:0] mac);
        logic [31:0] l, a0, a1, a2, a3, t;
        logic [15:0] h;
        h  = {rev8(mac[47:40]), rev8(mac[39:32])};
        l  = {rev8(mac[31:24]), rev8(mac[23:16]), rev8(mac[15:8]), rev8(mac[7:0])};
        a0 = (l >> 2) & 32'h3f;
        a1 = (l & 32'h3) | (((l >> 8) & 32'h7f) << 2);
        a2 = (l >> 15) & 32'h1ff;
        a3 = ((l >> 24) & 32'hff) | ({16'd0, h} & 32'h1) << 8;
        t  = ((a0 << 9) | (a1 ^ a2 ^ a3)) & 32'h7ff;
        return t[10:0];
    endfunction

    function automatic logic [31:0] f_lo(input logic [47:0] mac, input bit skip, input bit rx);
        logic [31:0] mh, ml, r;
        mh = {16'd0, mac[47:32]};
        ml = mac[31:0];
        r  = 32'h1 | (32'(skip) << 1) | (32'(rx) << 2);
        r |= ((mh >> 8)  & 32'hf) << 3;
        r |= ((mh >> 12) & 32'hf) << 7;
        r |= (mh & 32'hf) << 11;
        r |= ((mh >> 4)  & 32'hf) << 15;
        r |= ((ml >> 24) & 32'hf) << 19;
        r |= ((ml >> 28) & 32'hf) << 23;
        r |= ((ml >> 16) & 32'hf) << 27;
        r |= ((ml >> 20) & 32'h1) << 31;
        return r;
    endfunction

    function automatic logic [31:0] f_hi(input logic [47:0] mac);
        logic [31:0] ml;
        ml = mac[31:0];
        return ((ml >> 21) & 32'h7) | (((ml >> 8) & 32'hf) << 3) |
               (((ml >> 12) & 32'hf) << 7) | ((ml & 32'hf) << 11) |
               (((ml >> 4) & 32'hf) << 15);
    endfunction

    function automatic logic [47:0] rmac();
        logic [47:0] m;
        m = {16'($urandom()), $urandom()};
        return m;
    endfunction

    task automatic wr(input logic [10:0] idx, input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        wr_en = 1'b1; wr_index = idx; wr_lo = lo; wr_hi = hi;
        m_lo[idx] = lo; m_hi[idx] = hi;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic decoy(input logic [10:0] idx);
        wr(idx, ($urandom() & 32'hffff_fff8) | 32'h1 | ($urandom() & 32'h6),
           $urandom() & 32'h7ffff);
    endtask

    task automatic ins(input logic [47:0] mac, input bit skip, input bit rx);
        logic [10:0] s;
        logic [31:0] lo, hi;
        s  = f_hash(mac);
        lo = f_lo(mac, skip, rx);
        hi = f_hi(mac);
        for (int i = 0; i < HOPS; i++) begin
            if (!m_lo[s][0] || (((m_lo[s] ^ lo) & 32'hffff_fff8) == 0 && m_hi[s] == hi)) break;
            s++;
        end
        wr(s, lo, hi);
    endtask

    task automatic model(input logic [47:0] mac, output bit hit, output bit rej,
                         output bit rx, output logic [10:0] idx, output int pr);
        logic [31:0] klo, khi;
        logic [10:0] s;
        klo = f_lo(mac, 0, 0) & 32'hffff_fff8;
        khi = f_hi(mac);
        s = f_hash(mac);
        hit = 0; pr = 0; idx = s;
        for (int i = 0; i < HOPS; i++) begin
            pr = i + 1; idx = s;
            if (m_lo[s][0] && (m_lo[s] & 32'hffff_fff8) == klo && m_hi[s] == khi) begin
                hit = 1; break;
            end
            if (!m_lo[s][0]) break;
            s++;
        end
        rej = hit && m_lo[idx][1];
        rx  = hit && m_lo[idx][2];
    endtask

    task automatic lookup(input logic [47:0] mac, input string req, input bit poke);
        bit e_hit, e_rej, e_rx;
        logic [10:0] e_idx;
        int e_pr, lat;
        model(mac, e_hit, e_rej, e_rx, e_idx, e_pr);
        @(negedge clk);
        chk("R8", "ready before request", lk_ready, 1);
        lk_valid = 1'b1; lk_mac = mac;
        @(posedge clk);
        @(negedge clk);
        lk_valid = poke; lk_mac = ~mac;
        lat = 0;
        while (!res_valid && lat < 40) begin
            @(negedge clk);
            lk_valid = 1'b0;
            lat++;
        end
        chk("R6", {req, " latency"}, lat, e_pr);
        chk(req, "hit", res_hit, e_hit);
        chk("R7", {req, " reject"}, res_reject, e_rej);
        chk("R7", {req, " rx attribute"}, res_rx_attr, e_rx);
        chk(req, "index", res_index, e_idx);
        chk(req, "probes", res_probes, e_pr);
        @(negedge clk);
        chk("R6", "single strobe", res_valid, 0);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                chk("R8", "no result for request made while busy", res_valid, 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] a, w, p;
        logic [47:0] pool [48];
        logic [10:0] s;
        logic [31:0] lo_tmp;
        int k;

        void'($urandom(32'd20931));
        rst_n = 1'b0; wr_en = 1'b0; wr_index = '0; wr_lo = '0; wr_hi = '0;
        lk_valid = 1'b0; lk_mac = '0;
        for (int i = 0; i < 2048; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R9", "ready in reset", lk_ready, 1);
        chk("R9", "no strobe in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "ready after reset", lk_ready, 1);
        chk("R9", "no strobe after reset", res_valid, 0);

        for (int i = 0; i < 2048; i++) wr(11'(i), 32'h0, 32'h0);

        // R1 and R10: first-probe hit lands on the computed slot
        a = 48'h0050_c2a1_b2c3;
        ins(a, 0, 1);
        lookup(a, "R1", 0);
        chk("R1", "index equals hash", res_index, f_hash(a));
        chk("R10", "written entry hits", res_hit, 1);

        // R7: skip entry reported as reject
        a = 48'h3c1e_0011_ff07;
        ins(a, 1, 0);
        lookup(a, "R7", 0);
        chk("R7", "reject on skip entry", res_reject, 1);

        // R2: attribute bits ignored in compare; single-bit difference misses
        a = 48'h9a8b_7c6d_5e4f;
        s = f_hash(a);
        wr(s, f_lo(a, 1, 1), f_hi(a));
        wr(s + 11'd1, 32'h0, 32'h0);
        lookup(a, "R2", 0);
        chk("R2", "attr bits ignored", res_hit, 1);
        wr(s, f_lo(a, 0, 0), f_hi(a) ^ 32'h0000_0400);
        lookup(a, "R2", 0);
        chk("R2", "high word differs: miss", res_hit, 0);
        chk("R2", "high word differs: two probes", res_probes, 2);
        lo_tmp = f_lo(a, 0, 0) ^ 32'h0800_0000;
        wr(s, lo_tmp, f_hi(a));
        lookup(a, "R2", 0);
        chk("R2", "low word differs: miss", res_hit, 0);

        // R3: matching address but valid clear
        wr(s, f_lo(a, 0, 0) & 32'hffff_fffe, f_hi(a));
        lookup(a, "R3", 0);
        chk("R3", "invalid slot ends as miss", res_probes, 1);
        chk("R3", "invalid slot miss", res_hit, 0);

        // R4: wrap from slot 2047 to slot 0
        w = rmac();
        for (int i = 0; i < 200000 && f_hash(w) != 11'h7fe; i++) w = rmac();
        chk("R4", "found address at slot 2046", f_hash(w), 11'h7fe);
        decoy(11'h7fe); decoy(11'h7ff); decoy(11'h000);
        wr(11'h001, f_lo(w, 0, 1), f_hi(w));
        lookup(w, "R4", 0);
        chk("R4", "wrapped hit slot", res_index, 1);
        chk("R4", "wrapped probes", res_probes, 4);

        // R5: hop budget exhausted, then hit on the last allowed hop (poke R8)
        p = rmac();
        s = f_hash(p);
        for (int i = 0; i < HOPS; i++) decoy(s + 11'(i));
        wr(s + 11'(HOPS), f_lo(p, 0, 0), f_hi(p));
        lookup(p, "R5", 1);
        chk("R5", "exhausted budget miss", res_hit, 0);
        chk("R5", "exhausted probes", res_probes, HOPS);
        wr(s + 11'(HOPS - 1), f_lo(p, 1, 1), f_hi(p));
        lookup(p, "R5", 0);
        chk("R5", "hit on last hop", res_hit, 1);

        // random phase with decoy clusters
        for (int i = 0; i < 48; i++) begin
            pool[i] = rmac();
            s = f_hash(pool[i]);
            k = $urandom_range(0, 3);
            for (int j = 0; j < k; j++) decoy(s + 11'(j));
            ins(pool[i], 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        for (int i = 0; i < 150; i++) begin
            k = $urandom_range(0, 3);
            if (k <= 1) lookup(pool[$urandom_range(0, 47)], "R6", k == 1);
            else if (k == 2) lookup(pool[$urandom_range(0, 47)] ^ (48'd1 << $urandom_range(0, 47)), "R2", 0);
            else lookup(rmac(), "R3", 0);
            if ((i % 25) == 0) begin
                a = rmac();
                ins(a, 0, 1);
                lookup(a, "R10", 0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule